// File: doc/BRIEF.md
# Serial Lane Deserializer with Power-Down Hold

This block rebuilds one 21-bit pixel word from three serial data lanes. A fourth lane carries a forwarded clock. Each lane delivers seven bit slots per pixel period. The block runs on a sample clock at seven times the pixel rate, so it sees one bit per lane per cycle. It finds the frame boundary from the fixed high/low shape of the clock lane. It shifts the three data lanes in and places each lane's seven bits into a fixed range of the output word. It then presents the word on a parallel bus together with a recovered pixel clock, whose falling edge marks valid data.

The output word updates only after the clock lane has shown its expected shape for several frames in a row. Pulling the active-low power-down input low freezes the word at its last value, drops the recovered clock and the lock flag, and clears the alignment state. Alignment then starts from scratch when the input is released.

Top module: `lvds_lane_deser`

## Requirements
- R1: In each frame, the bit that data lane i carries in slot k (slots sent 0 first, 6 last) appears at pix_word bit 7*i+k. Lane 0 fills bits 6:0, lane 1 fills bits 13:7 and lane 2 fills bits 20:14.
- R2: The fields of pix_word are red at [5:0], green at [11:6], blue at [17:12], line sync at bit 18, frame sync at bit 19 and data enable at bit 20.
- R3: A valid frame shows the clock lane as 1,1,0,0,0,1,1 in slots 0 to 6. A 1-to-0 change on the clock lane marks slot 2 and realigns the slot counter there. The frame ends on the cycle that carries slot 6.
- R4: `locked` rises at the end of the 4th consecutive frame whose clock lane matches the pattern. It clears at the end of any frame whose clock lane does not match.
- R5: pix_word loads once per frame, on the frame-end cycle. It loads only when `locked` was already high before that frame and the frame matches. Otherwise it keeps its value, so the first word loaded is the one from the 5th matching frame.
- R6: While locked, pix_clk is high in the cycles that follow the edges sampling slots 6, 0, 1 and 2, and low in the cycles that follow the edges sampling slots 3, 4 and 5. It is low while unlocked. pix_word never changes on a cycle where pix_clk falls.
- R7: While pwr_n is low, pix_word holds its value and pix_clk and locked are 0. The slot counter and the match count restart, so after release four new matching frames are needed before locked rises, and the fifth frame loads.
- R8: A pwr_n low on the frame-end cycle of a matching, locked frame cancels that frame's load.
- R9: After a synchronous reset, pix_word is 0, pix_clk is 0 and locked is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, seven cycles per pixel period |
| rst | input | 1 | Synchronous active-high reset |
| pwr_n | input | 1 | Active-low power-down; low freezes the word |
| lane_data | input | 3 | One sampled bit per data lane per cycle |
| lane_clk | input | 1 | Sampled bit of the forwarded clock lane |
| pix_word | output | 21 | Rebuilt parallel pixel word |
| pix_clk | output | 1 | Recovered pixel clock; falling edge strobes pix_word |
| locked | output | 1 | Frame alignment established |

## Verification
Two events can fall on the same frame-end cycle: the word load and either a pattern mismatch or a power-down. The bench sends a frame whose clock lane differs from the pattern only in slot 4, so the realignment edge stays in place. It checks that the word keeps its old value while lock drops in that same cycle. It also pulls pwr_n low on exactly the slot-6 cycle of a valid locked frame and expects no load. A mid-stream phase jump, inserted by extra bits, checks that a mismatch ends the interrupted frame and that lock is only regained after four fresh frames.

// File: rtl/lvds_deser_pkg.sv
package lvds_deser_pkg;

    localparam int SLOTS      = 7;
    localparam int DLANES     = 3;
    localparam int WORD_W     = SLOTS * DLANES;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int LAST_SLOT  = SLOTS - 1;
    localparam int FALL_SLOT  = 2;
    localparam logic [SLOTS-1:0] CLK_SHAPE = 7'b1100011;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [SLOTS-1:0]  lane_bits_t;

    typedef struct packed {
        logic       de;
        logic       vsync;
        logic       hsync;
        logic [5:0] blu;
        logic [5:0] grn;
        logic [5:0] red;
    } pix_word_t;

    function automatic slot_t slot_after(slot_t s);
        return (s == slot_t'(LAST_SLOT)) ? slot_t'(0) : slot_t'(s + slot_t'(1));
    endfunction

    function automatic logic strobe_phase(slot_t s);
        return (s == slot_t'(LAST_SLOT)) || (s <= slot_t'(FALL_SLOT));
    endfunction

endpackage

// File: rtl/lane_shifter.sv
module lane_shifter
    import lvds_deser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_in,
    output lane_bits_t sh_next
);
    lane_bits_t sh_q;

    // first bit in ends at index 0 after a full frame
    assign sh_next = {bit_in, sh_q[SLOTS-1:1]};

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_next;
    end
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
    import lvds_deser_pkg::*;
#(
    parameter int LOCK_FRAMES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_n,
    input  logic       clk_bit,
    input  lane_bits_t clk_sh_next,
    output logic       frame_end,
    output logic       shape_ok,
    output logic       lock_q,
    output logic       lock_d,
    output slot_t      cur_slot
);
    localparam int CNT_W = $clog2(LOCK_FRAMES + 1);

    slot_t            slot_q;
    logic             prev_q;
    logic             fall_seen;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign fall_seen = prev_q & ~clk_bit;
    assign cur_slot  = fall_seen ? slot_t'(FALL_SLOT) : slot_q;
    assign frame_end = pwr_n && (cur_slot == slot_t'(LAST_SLOT));
    assign shape_ok  = (clk_sh_next == CLK_SHAPE);

    always_comb begin
        cnt_d  = cnt_q;
        lock_d = lock_q;
        if (!pwr_n) begin
            cnt_d  = '0;
            lock_d = 1'b0;
        end else if (frame_end) begin
            if (shape_ok) begin
                cnt_d  = (cnt_q == CNT_W'(LOCK_FRAMES)) ? cnt_q : CNT_W'(cnt_q + CNT_W'(1));
                lock_d = (cnt_q >= CNT_W'(LOCK_FRAMES - 1));
            end else begin
                cnt_d  = '0;
                lock_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_n) begin
            slot_q <= '0;
            prev_q <= 1'b0;
        end else begin
            slot_q <= slot_after(cur_slot);
            prev_q <= clk_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            lock_q <= lock_d;
        end
    end

    // R4
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> $past(frame_end) && $past(shape_ok));

    // R4
    lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_q) |-> ($past(frame_end) || !$past(pwr_n)));

    // R3
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot_q <= slot_t'(LAST_SLOT));
endmodule

// File: rtl/word_capture.sv
module word_capture
    import lvds_deser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_n,
    input  logic              frame_end,
    input  logic              shape_ok,
    input  logic              lock_q,
    input  logic              lock_d,
    input  slot_t             cur_slot,
    input  logic [WORD_W-1:0] word_next,
    output pix_word_t         word_q,
    output logic              pix_clk_q
);
    logic load;

    assign load = frame_end && shape_ok && lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q    <= '0;
            pix_clk_q <= 1'b0;
        end else begin
            if (load) word_q <= pix_word_t'(word_next);
            pix_clk_q <= pwr_n && lock_d && strobe_phase(cur_slot);
        end
    end

    // R6
    strobe_stable_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pix_clk_q) |-> $stable(word_q));

    // R7
    pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_n |=> $stable(word_q) && !pix_clk_q);

    // R5
    load_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !lock_q |=> $stable(word_q));
endmodule

// File: rtl/lvds_lane_deser.sv
module lvds_lane_deser
    import lvds_deser_pkg::*;
#(
    parameter int LOCK_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_n,
    input  logic [DLANES-1:0] lane_data,
    input  logic              lane_clk,
    output logic [WORD_W-1:0] pix_word,
    output logic              pix_clk,
    output logic              locked
);
    lane_bits_t        data_sh [DLANES];
    lane_bits_t        clk_sh;
    logic [WORD_W-1:0] word_next;
    logic              frame_end, shape_ok, lock_q, lock_d;
    slot_t             cur_slot;
    pix_word_t         word_q;

    for (genvar i = 0; i < DLANES; i++) begin : g_lane
        lane_shifter u_sh (
            .clk     (clk),
            .rst     (rst),
            .bit_in  (lane_data[i]),
            .sh_next (data_sh[i])
        );
        assign word_next[i*SLOTS +: SLOTS] = data_sh[i];
    end

    lane_shifter u_clk_sh (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (lane_clk),
        .sh_next (clk_sh)
    );

    frame_aligner #(.LOCK_FRAMES(LOCK_FRAMES)) u_align (
        .clk         (clk),
        .rst         (rst),
        .pwr_n       (pwr_n),
        .clk_bit     (lane_clk),
        .clk_sh_next (clk_sh),
        .frame_end   (frame_end),
        .shape_ok    (shape_ok),
        .lock_q      (lock_q),
        .lock_d      (lock_d),
        .cur_slot    (cur_slot)
    );

    word_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .pwr_n     (pwr_n),
        .frame_end (frame_end),
        .shape_ok  (shape_ok),
        .lock_q    (lock_q),
        .lock_d    (lock_d),
        .cur_slot  (cur_slot),
        .word_next (word_next),
        .word_q    (word_q),
        .pix_clk_q (pix_clk)
    );

    assign pix_word = word_q;
    assign locked   = lock_q;

    // R6
    strobe_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        pix_clk |-> locked);
endmodule

// File: tb/sim_lvds_lane_deser.sv
module sim_lvds_lane_deser;
    logic        clk = 1'b0;
    logic        rst;
    logic        pwr_n;
    logic [2:0]  lane_data;
    logic        lane_clk;
    logic [20:0] pix_word;
    logic        pix_clk;
    logic        locked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [6:0]  obs_pclk;
    logic [20:0] exp_w;

    localparam logic [6:0] GOOD = 7'b1100011;
    localparam logic [6:0] BAD  = 7'b1110011;

    always #10 clk = ~clk;

    lvds_lane_deser u0 (
        .clk(clk), .rst(rst), .pwr_n(pwr_n), .lane_data(lane_data),
        .lane_clk(lane_clk), .pix_word(pix_word), .pix_clk(pix_clk), .locked(locked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [20:0] fields(input logic [5:0] r, input logic [5:0] g,
                                           input logic [5:0] b, input logic hs,
                                           input logic vs, input logic de);
        return {de, vs, hs, b, g, r};
    endfunction

    // lane i slot k carries word bit 7*i+k; pd_slot >= 0 pulls pwr_n low there
    task automatic send_frame(input logic [20:0] w, input logic [6:0] cp, input int pd_slot);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            for (int i = 0; i < 3; i++) lane_data[i] = w[i*7+k];
            lane_clk = cp[k];
            if (k == pd_slot) pwr_n = 1'b0;
            @(posedge clk);
            #2;
            obs_pclk[k] = pix_clk;
        end
    endtask

    task automatic send_bits(input logic [2:0] cbits, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            lane_data = 3'b000;
            lane_clk  = cbits[k];
            @(posedge clk);
            #2;
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [20:0] w;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0417);
        rst = 1'b1; pwr_n = 1'b1; lane_data = '0; lane_clk = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk("R9 word", {11'b0, pix_word}, 32'd0);
        chk("R9 pix_clk", {31'b0, pix_clk}, 32'd0);
        chk("R9 locked", {31'b0, locked}, 32'd0);
        @(negedge clk) rst = 1'b0;

        // R3: start mid-frame (slots 4..6 of the clock shape)
        send_bits(3'b110, 3);
        for (int f = 1; f <= 4; f++) begin
            send_frame(21'($urandom), GOOD, -1);
            chk("R4 lock count", {31'b0, locked}, (f == 4) ? 32'd1 : 32'd0);
            chk("R5 no load before lock", {11'b0, pix_word}, 32'd0);
        end
        exp_w = 21'($urandom);
        send_frame(exp_w, GOOD, -1);
        chk("R1 first load", {11'b0, pix_word}, {11'b0, exp_w});
        chk("R6 strobe shape", {25'b0, obs_pclk}, 32'b1000111);

        // R1 random frames
        for (int f = 0; f < 30; f++) begin
            exp_w = 21'($urandom);
            send_frame(exp_w, GOOD, -1);
            chk("R1 random word", {11'b0, pix_word}, {11'b0, exp_w});
        end

        // R2 field positions
        exp_w = fields(6'h2A, 6'h00, 6'h00, 1'b0, 1'b0, 1'b0);
        send_frame(exp_w, GOOD, -1);
        chk("R2 red", {26'b0, pix_word[5:0]}, 32'h2A);
        exp_w = fields(6'h00, 6'h15, 6'h00, 1'b0, 1'b0, 1'b0);
        send_frame(exp_w, GOOD, -1);
        chk("R2 green", {26'b0, pix_word[11:6]}, 32'h15);
        exp_w = fields(6'h00, 6'h00, 6'h33, 1'b0, 1'b0, 1'b0);
        send_frame(exp_w, GOOD, -1);
        chk("R2 blue", {26'b0, pix_word[17:12]}, 32'h33);
        exp_w = fields(6'h00, 6'h00, 6'h00, 1'b1, 1'b0, 1'b1);
        send_frame(exp_w, GOOD, -1);
        chk("R2 syncs", {29'b0, pix_word[20:18]}, 32'b101);

        // R4/R5: mismatch on the frame-end cycle beats the load
        send_frame(21'h1ABCDE, BAD, -1);
        chk("R4 mismatch clears lock", {31'b0, locked}, 32'd0);
        chk("R5 mismatch holds word", {11'b0, pix_word}, {11'b0, exp_w});
        for (int f = 1; f <= 4; f++) send_frame(21'($urandom), GOOD, -1);
        chk("R4 relock", {31'b0, locked}, 32'd1);
        chk("R5 held while relocking", {11'b0, pix_word}, {11'b0, exp_w});
        exp_w = 21'($urandom);
        send_frame(exp_w, GOOD, -1);
        chk("R5 load after relock", {11'b0, pix_word}, {11'b0, exp_w});

        // R3: phase jump by three extra bits
        send_bits(3'b110, 3);
        send_frame(21'($urandom), GOOD, -1);
        chk("R3 jump drops lock", {31'b0, locked}, 32'd0);
        chk("R3 jump holds word", {11'b0, pix_word}, {11'b0, exp_w});
        for (int f = 2; f <= 4; f++) send_frame(21'($urandom), GOOD, -1);
        chk("R3 realigned lock", {31'b0, locked}, 32'd1);
        exp_w = 21'($urandom);
        send_frame(exp_w, GOOD, -1);
        chk("R3 realigned word", {11'b0, pix_word}, {11'b0, exp_w});

        // R8: power-down lands on slot 6 of a locked good frame
        send_frame(21'h0F0F0F, GOOD, 6);
        chk("R8 load cancelled", {11'b0, pix_word}, {11'b0, exp_w});
        chk("R7 lock cleared", {31'b0, locked}, 32'd0);
        chk("R7 pix_clk low", {31'b0, pix_clk}, 32'd0);
        for (int f = 0; f < 3; f++) begin
            send_frame(21'($urandom), GOOD, -1);
            chk("R7 hold word", {11'b0, pix_word}, {11'b0, exp_w});
            chk("R7 no strobe", {25'b0, obs_pclk}, 32'd0);
            chk("R7 no lock", {31'b0, locked}, 32'd0);
        end
        @(negedge clk) pwr_n = 1'b1;
        for (int f = 1; f <= 4; f++) begin
            send_frame(21'($urandom), GOOD, -1);
            chk("R7 relock count", {31'b0, locked}, (f == 4) ? 32'd1 : 32'd0);
        end
        chk("R7 word before reload", {11'b0, pix_word}, {11'b0, exp_w});
        exp_w = 21'($urandom);
        send_frame(exp_w, GOOD, -1);
        chk("R7 reload", {11'b0, pix_word}, {11'b0, exp_w});
        chk("R6 strobe after wake", {25'b0, obs_pclk}, 32'b1000111);

        // mixed random: occasional bad frames, tracked by a lock model
        begin
            int run = 5;
            for (int f = 0; f < 40; f++) begin
                logic bad;
                bad = ($urandom % 6) == 0;
                w = 21'($urandom);
                send_frame(w, bad ? BAD : GOOD, -1);
                if (!bad && run >= 4) exp_w = w;
                run = bad ? 0 : run + 1;
                chk("R5 random mix word", {11'b0, pix_word}, {11'b0, exp_w});
                chk("R4 random mix lock", {31'b0, locked}, (run >= 4) ? 32'd1 : 32'd0);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule